// File: doc/BRIEF.md
# Load/Store Buffer Queue with Head Address Stage

This block holds the memory operations of a dynamically scheduled core in a small circular queue. When an operation is issued, a slot takes either a base-register value or the tag of the unit that will produce it. It also takes a sign-extended immediate and, for a store, either the data value or its producer tag. Every slot watches the core's result bus and replaces a pending tag with the broadcast value when the tags match. This includes a broadcast that arrives in the very cycle the slot is written.

Memory work happens only at the head, in program order. When the head's base operand is known, the head adds it to the immediate and keeps the sum as the effective address. A load then reads a synchronous memory port with one cycle of latency. It asks for the result bus and holds its tag and data until a grant arrives, and the slot is freed on the grant. A store waits at the head until its data operand is resolved, writes memory and frees its slot in the same cycle. When every slot is occupied, the issue stage is told to stall.

Top module: `ldst_queue`

## Requirements
- R1: After reset the queue is empty: `iss_ready_o` is 1, and `mem_en_o` and `ld_req_o` are 0.
- R2: With DEPTH slots occupied, `iss_ready_o` is 0. An issue offered while it is 0 is dropped and never reaches memory.
- R3: Slots are filled in circular order. The tag on `iss_tag_o` during an accepted issue is TAG_BASE plus the slot index, so with defaults the tags run 1,2,3,4,1,...
- R4: The effective address is the base value plus the IMM_W-bit immediate sign-extended to DATA_W. `mem_addr_o` carries its low ADDR_W bits.
- R5: The head performs no address step and no memory access while its base tag is nonzero. Tag 0 means the value is present.
- R6: Memory accesses occur strictly in issue order. A younger slot with ready operands waits behind an older, blocked head.
- R7: A load whose base is ready at issue raises `ld_req_o` three clock edges after the issue edge. It presents its own tag and the word read from the effective address.
- R8: While `ld_req_o` is high and `ld_gnt_i` is low, `ld_req_o`, `ld_tag_o` and `ld_data_o` stay unchanged. The slot is freed at the edge where the grant is seen.
- R9: A store does not write memory while its data tag is pending. Once the tag is resolved, it writes the data at the effective address with `mem_we_o`=1.
- R10: A result-bus broadcast fills the base or data operand of every slot whose pending tag equals `rb_tag_i`. A broadcast with any other tag changes nothing.
- R11: A broadcast in the same cycle as an issue whose operand tag equals `rb_tag_i` is captured at issue.
- R12: An issue and a slot release in the same cycle leave the occupancy unchanged. Afterwards the queue still fills to exactly DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid_i | input | 1 | Issue request |
| iss_store_i | input | 1 | 1 for a store, 0 for a load |
| iss_base_val_i | input | DATA_W | Base value, used when base tag is 0 |
| iss_base_tag_i | input | TAG_W | Producer tag of the base, 0 if present |
| iss_imm_i | input | IMM_W | Signed immediate offset |
| iss_data_val_i | input | DATA_W | Store data value, used when data tag is 0 |
| iss_data_tag_i | input | TAG_W | Producer tag of the store data, 0 if present |
| iss_ready_o | output | 1 | A slot is free |
| iss_tag_o | output | TAG_W | Tag given to the slot being filled |
| rb_valid_i | input | 1 | Result bus carries a value |
| rb_tag_i | input | TAG_W | Producer tag on the result bus |
| rb_data_i | input | DATA_W | Value on the result bus |
| ld_req_o | output | 1 | Load asks for the result bus |
| ld_tag_o | output | TAG_W | Tag of the requesting load |
| ld_data_o | output | DATA_W | Loaded word |
| ld_gnt_i | input | 1 | Result bus granted to the load |
| mem_en_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid one cycle after a read |

## Verification
Two pairs of events can land in one cycle. The first pair is a result-bus broadcast and an issue that names the broadcast tag. The bench drives both on the same edge and checks that the store later writes the broadcast value, and that the load reads at the broadcast base. The second pair is an issue and a store retirement. The bench waits until a write is visible on the memory port and offers a new store at that edge. It then checks that the new store lands and that `iss_ready_o` drops after exactly the expected number of further issues.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

   // Phase of the operation sitting at the queue head.
   typedef enum logic [1:0] {
      PH_ADDR   = 2'd0,   // waiting for base, then forms the address
      PH_ACCESS = 2'd1,   // drives the memory port
      PH_WAIT   = 2'd2,   // load read data returns
      PH_BCAST  = 2'd3    // load waits for a result-bus grant
   } lsq_phase_e;

endpackage

// File: rtl/lsq_ptrs.sv
module lsq_ptrs #(
   parameter int DEPTH = 4,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   output logic [IDX_W-1:0] head_o,
   output logic [IDX_W-1:0] tail_o,
   output logic             full_o,
   output logic             empty_o
);

   logic [IDX_W-1:0] head_q, tail_q, head_nx, tail_nx;
   logic [CNT_W-1:0] count_q;

   // Wrap logic: free for power-of-two depths, explicit compare otherwise.
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         always_comb begin
            head_nx = head_q + 1'b1;
            tail_nx = tail_q + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_comb begin
            head_nx = (head_q == IDX_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
            tail_nx = (tail_q == IDX_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         if (push_i) tail_q <= tail_nx;
         if (pop_i)  head_q <= head_nx;
         case ({push_i, pop_i})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign head_o  = head_q;
   assign tail_o  = tail_q;
   assign full_o  = (count_q == CNT_W'(DEPTH));
   assign empty_o = (count_q == '0);

   // R2: the issue side never pushes into a full queue
   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);

   // R12: a release always refers to an occupied slot
   p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);

   // R12: simultaneous push and pop keep occupancy
   p_push_pop_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i) |=> ($stable(full_o) && $stable(empty_o)));

endmodule

// File: rtl/lsq_entry.sv
module lsq_entry #(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_i,
   input  logic              alloc_store_i,
   input  logic [DATA_W-1:0] alloc_vj_i,
   input  logic [TAG_W-1:0]  alloc_qj_i,
   input  logic [DATA_W-1:0] alloc_vk_i,
   input  logic [TAG_W-1:0]  alloc_qk_i,
   input  logic [DATA_W-1:0] alloc_a_i,
   input  logic              addr_step_i,
   input  logic              release_i,
   input  logic              bus_valid_i,
   input  logic [TAG_W-1:0]  bus_tag_i,
   input  logic [DATA_W-1:0] bus_data_i,
   output logic              busy_o,
   output logic              store_o,
   output logic [TAG_W-1:0]  qj_o,
   output logic [DATA_W-1:0] vj_o,
   output logic [TAG_W-1:0]  qk_o,
   output logic [DATA_W-1:0] vk_o,
   output logic [DATA_W-1:0] a_o
);

   logic              busy_q, store_q;
   logic [TAG_W-1:0]  qj_q, qk_q;
   logic [DATA_W-1:0] vj_q, vk_q, a_q;

   // Bus matches: for operands arriving at issue, and for held operands.
   logic new_j_hit, new_k_hit, held_j_hit, held_k_hit;

   always_comb begin
      new_j_hit  = bus_valid_i && (alloc_qj_i != '0) && (bus_tag_i == alloc_qj_i);
      new_k_hit  = bus_valid_i && (alloc_qk_i != '0) && (bus_tag_i == alloc_qk_i);
      held_j_hit = bus_valid_i && (qj_q != '0) && (bus_tag_i == qj_q);
      held_k_hit = bus_valid_i && (qk_q != '0) && (bus_tag_i == qk_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         store_q <= 1'b0;
         qj_q    <= '0;
         qk_q    <= '0;
         vj_q    <= '0;
         vk_q    <= '0;
         a_q     <= '0;
      end else if (alloc_i) begin
         busy_q  <= 1'b1;
         store_q <= alloc_store_i;
         a_q     <= alloc_a_i;
         if (new_j_hit) begin
            vj_q <= bus_data_i;
            qj_q <= '0;
         end else begin
            vj_q <= alloc_vj_i;
            qj_q <= alloc_qj_i;
         end
         if (new_k_hit) begin
            vk_q <= bus_data_i;
            qk_q <= '0;
         end else begin
            vk_q <= alloc_vk_i;
            qk_q <= alloc_qk_i;
         end
      end else if (busy_q) begin
         if (release_i) busy_q <= 1'b0;
         if (held_j_hit) begin
            vj_q <= bus_data_i;
            qj_q <= '0;
         end
         if (held_k_hit) begin
            vk_q <= bus_data_i;
            qk_q <= '0;
         end
         if (addr_step_i) a_q <= vj_q + a_q;
      end
   end

   assign busy_o  = busy_q;
   assign store_o = store_q;
   assign qj_o    = qj_q;
   assign vj_o    = vj_q;
   assign qk_o    = qk_q;
   assign vk_o    = vk_q;
   assign a_o     = a_q;

   // R2: a slot is only filled when it is free
   p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |-> !busy_o);

   // R5: the controller forms an address only from a present base
   p_base_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      addr_step_i |-> (busy_o && (qj_o == '0)));

   // R9: a store slot is released only with its data present
   p_store_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (release_i && store_o) |-> (qk_o == '0));

   // R10: a matching broadcast resolves a held data operand next cycle
   p_snoop_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !alloc_i && !release_i && bus_valid_i && (qk_o != '0) && (bus_tag_i == qk_o))
      |=> ((qk_o == '0) && (vk_o == $past(bus_data_i))));

endmodule

// File: rtl/lsq_head_ctrl.sv
module lsq_head_ctrl
   import lsq_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int TAG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              head_busy_i,
   input  logic              head_store_i,
   input  logic [TAG_W-1:0]  head_qj_i,
   input  logic [TAG_W-1:0]  head_qk_i,
   input  logic [DATA_W-1:0] head_vk_i,
   input  logic [DATA_W-1:0] head_a_i,
   input  logic [TAG_W-1:0]  head_tag_i,
   output logic              addr_step_o,
   output logic              pop_o,
   output logic              mem_en_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              ld_req_o,
   output logic [TAG_W-1:0]  ld_tag_o,
   output logic [DATA_W-1:0] ld_data_o,
   input  logic              ld_gnt_i
);

   lsq_phase_e        phase_q, phase_nx;
   logic [DATA_W-1:0] ld_data_q;
   logic              store_go, load_go;

   always_comb begin
      store_go    = (phase_q == PH_ACCESS) && head_store_i && (head_qk_i == '0);
      load_go     = (phase_q == PH_ACCESS) && !head_store_i;
      addr_step_o = (phase_q == PH_ADDR) && head_busy_i && (head_qj_i == '0);
      mem_en_o    = store_go || load_go;
      mem_we_o    = store_go;
      ld_req_o    = (phase_q == PH_BCAST);
      pop_o       = store_go || (ld_req_o && ld_gnt_i);

      phase_nx = phase_q;
      case (phase_q)
         PH_ADDR:   if (addr_step_o) phase_nx = PH_ACCESS;
         PH_ACCESS: begin
            if (store_go)     phase_nx = PH_ADDR;
            else if (load_go) phase_nx = PH_WAIT;
         end
         PH_WAIT:   phase_nx = PH_BCAST;
         PH_BCAST:  if (ld_gnt_i) phase_nx = PH_ADDR;
         default:   phase_nx = PH_ADDR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= PH_ADDR;
         ld_data_q <= '0;
      end else begin
         phase_q <= phase_nx;
         if (phase_q == PH_WAIT) ld_data_q <= mem_rdata_i;
      end
   end

   assign mem_addr_o  = head_a_i[ADDR_W-1:0];
   assign mem_wdata_o = head_vk_i;
   assign ld_tag_o    = head_tag_i;
   assign ld_data_o   = ld_data_q;

   // R7: a read is followed by one latency cycle, then the bus request
   p_read_to_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en_o && !mem_we_o) |=> (!mem_en_o && !ld_req_o) ##1 ld_req_o);

   // R8: an ungranted request holds its tag and data
   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_req_o && !ld_gnt_i) |=> (ld_req_o && $stable(ld_tag_o) && $stable(ld_data_o)));

   // R6: no memory access while a load waits for the bus
   p_single_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req_o |-> !mem_en_o);

endmodule

// File: rtl/ldst_queue.sv
module ldst_queue #(
   parameter int DEPTH    = 4,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int TAG_W    = 4,
   parameter int IMM_W    = 12,
   parameter int TAG_BASE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid_i,
   input  logic              iss_store_i,
   input  logic [DATA_W-1:0] iss_base_val_i,
   input  logic [TAG_W-1:0]  iss_base_tag_i,
   input  logic [IMM_W-1:0]  iss_imm_i,
   input  logic [DATA_W-1:0] iss_data_val_i,
   input  logic [TAG_W-1:0]  iss_data_tag_i,
   output logic              iss_ready_o,
   output logic [TAG_W-1:0]  iss_tag_o,
   input  logic              rb_valid_i,
   input  logic [TAG_W-1:0]  rb_tag_i,
   input  logic [DATA_W-1:0] rb_data_i,
   output logic              ld_req_o,
   output logic [TAG_W-1:0]  ld_tag_o,
   output logic [DATA_W-1:0] ld_data_o,
   input  logic              ld_gnt_i,
   output logic              mem_en_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i
);

   localparam int IDX_W = $clog2(DEPTH);

   // Elaboration-time parameter checks.
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ldst_queue: DEPTH must be at least 2");
      end
      if (IMM_W > DATA_W) begin : g_bad_imm
         $error("ldst_queue: IMM_W must not exceed DATA_W");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("ldst_queue: ADDR_W must not exceed DATA_W");
      end
      if (TAG_BASE < 1 || (TAG_BASE + DEPTH) > (1 << TAG_W)) begin : g_bad_tag
         $error("ldst_queue: slot tags must be nonzero and fit TAG_W");
      end
   endgenerate

   logic [IDX_W-1:0]  head_idx, tail_idx;
   logic              full, empty, push, pop, addr_step;
   logic [DATA_W-1:0] imm_ext;

   logic              busy_w  [DEPTH];
   logic              store_w [DEPTH];
   logic [TAG_W-1:0]  qj_w    [DEPTH];
   logic [TAG_W-1:0]  qk_w    [DEPTH];
   logic [DATA_W-1:0] vj_w    [DEPTH];
   logic [DATA_W-1:0] vk_w    [DEPTH];
   logic [DATA_W-1:0] a_w     [DEPTH];

   assign iss_ready_o = !full;
   assign push        = iss_valid_i && !full;
   assign iss_tag_o   = TAG_W'(TAG_BASE + int'(tail_idx));
   assign imm_ext     = DATA_W'($signed(iss_imm_i));

   lsq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push),
      .pop_i   (pop),
      .head_o  (head_idx),
      .tail_o  (tail_idx),
      .full_o  (full),
      .empty_o (empty)
   );

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         lsq_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
            .clk           (clk),
            .rst_n         (rst_n),
            .alloc_i       (push && (tail_idx == IDX_W'(i))),
            .alloc_store_i (iss_store_i),
            .alloc_vj_i    (iss_base_val_i),
            .alloc_qj_i    (iss_base_tag_i),
            .alloc_vk_i    (iss_data_val_i),
            .alloc_qk_i    (iss_store_i ? iss_data_tag_i : '0),
            .alloc_a_i     (imm_ext),
            .addr_step_i   (addr_step && (head_idx == IDX_W'(i))),
            .release_i     (pop && (head_idx == IDX_W'(i))),
            .bus_valid_i   (rb_valid_i),
            .bus_tag_i     (rb_tag_i),
            .bus_data_i    (rb_data_i),
            .busy_o        (busy_w[i]),
            .store_o       (store_w[i]),
            .qj_o          (qj_w[i]),
            .vj_o          (vj_w[i]),
            .qk_o          (qk_w[i]),
            .vk_o          (vk_w[i]),
            .a_o           (a_w[i])
         );
      end
   endgenerate

   lsq_head_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .head_busy_i  (busy_w[head_idx]),
      .head_store_i (store_w[head_idx]),
      .head_qj_i    (qj_w[head_idx]),
      .head_qk_i    (qk_w[head_idx]),
      .head_vk_i    (vk_w[head_idx]),
      .head_a_i     (a_w[head_idx]),
      .head_tag_i   (TAG_W'(TAG_BASE + int'(head_idx))),
      .addr_step_o  (addr_step),
      .pop_o        (pop),
      .mem_en_o     (mem_en_o),
      .mem_we_o     (mem_we_o),
      .mem_addr_o   (mem_addr_o),
      .mem_wdata_o  (mem_wdata_o),
      .mem_rdata_i  (mem_rdata_i),
      .ld_req_o     (ld_req_o),
      .ld_tag_o     (ld_tag_o),
      .ld_data_o    (ld_data_o),
      .ld_gnt_i     (ld_gnt_i)
   );

   // R6: memory is touched only on behalf of an occupied head slot
   p_access_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en_o |-> (busy_w[head_idx] && !empty));

   // R1: an empty queue drives no memory access and no bus request
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (!mem_en_o && !ld_req_o));

   // R3: the issue tag follows the fill pointer
   p_tag_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !$isunknown(iss_tag_o)) |=> (iss_tag_o != $past(iss_tag_o)));

endmodule

// File: tb/ldst_queue_tb_top.sv
module ldst_queue_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_valid = 1'b0, iss_store = 1'b0;
   logic [31:0] iss_base_val = '0, iss_data_val = '0;
   logic [3:0]  iss_base_tag = '0, iss_data_tag = '0;
   logic [11:0] iss_imm = '0;
   logic        iss_ready_o;
   logic [3:0]  iss_tag_o;
   logic        rb_valid = 1'b0;
   logic [3:0]  rb_tag = '0;
   logic [31:0] rb_data = '0;
   logic        ld_req_o, ld_gnt = 1'b1;
   logic [3:0]  ld_tag_o;
   logic [31:0] ld_data_o;
   logic        mem_en_o, mem_we_o;
   logic [7:0]  mem_addr_o;
   logic [31:0] mem_wdata_o, mem_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   ldst_queue dut_i (
      .clk(clk), .rst_n(rst_n),
      .iss_valid_i(iss_valid), .iss_store_i(iss_store),
      .iss_base_val_i(iss_base_val), .iss_base_tag_i(iss_base_tag),
      .iss_imm_i(iss_imm), .iss_data_val_i(iss_data_val), .iss_data_tag_i(iss_data_tag),
      .iss_ready_o(iss_ready_o), .iss_tag_o(iss_tag_o),
      .rb_valid_i(rb_valid), .rb_tag_i(rb_tag), .rb_data_i(rb_data),
      .ld_req_o(ld_req_o), .ld_tag_o(ld_tag_o), .ld_data_o(ld_data_o), .ld_gnt_i(ld_gnt),
      .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata)
   );

   int checks = 0, failures = 0;
   int exp_tail = 0;
   logic [3:0] last_tag;

   // Memory model and activity logs.
   logic [31:0] mem [256];
   int          acc_n = 0, bc_n = 0;
   logic        acc_we   [64];
   logic [7:0]  acc_addr [64];
   logic [3:0]  bc_tag   [64];
   logic [31:0] bc_data  [64];

   function automatic logic [31:0] minit(input int a);
      return 32'hA000_0000 + 32'(a) * 32'd7;
   endfunction

   always @(posedge clk) begin
      if (mem_en_o) begin
         if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
         else          mem_rdata <= mem[mem_addr_o];
         if (acc_n < 64) begin
            acc_we[acc_n]   = mem_we_o;
            acc_addr[acc_n] = mem_addr_o;
         end
         acc_n = acc_n + 1;
      end
      if (ld_req_o && ld_gnt) begin
         if (bc_n < 64) begin
            bc_tag[bc_n]  = ld_tag_o;
            bc_data[bc_n] = ld_data_o;
         end
         bc_n = bc_n + 1;
      end
   end

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // Called at a negedge; returns at the following negedge.
   task automatic do_issue(input bit st, input logic [31:0] bv, input logic [3:0] bt,
                           input logic [11:0] imm, input logic [31:0] dv, input logic [3:0] dt);
      iss_valid = 1'b1; iss_store = st; iss_base_val = bv; iss_base_tag = bt;
      iss_imm = imm; iss_data_val = dv; iss_data_tag = dt;
      #1;
      if (iss_ready_o) begin
         last_tag = 4'(1 + exp_tail);
         chk(iss_tag_o == last_tag, "R3 issue tag", 32'(iss_tag_o), 32'(last_tag));
         exp_tail = (exp_tail + 1) % 4;
      end
      @(negedge clk);
      iss_valid = 1'b0;
   endtask

   task automatic bcast(input logic [3:0] t, input logic [31:0] d);
      rb_valid = 1'b1; rb_tag = t; rb_data = d;
      @(negedge clk);
      rb_valid = 1'b0;
   endtask

   task automatic wait_acc(input int n);
      for (int i = 0; i < 40 && acc_n < n; i++) @(negedge clk);
   endtask

   task automatic wait_bc(input int n);
      for (int i = 0; i < 40 && bc_n < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(iss_ready_o == 1'b1, "R1 ready after reset", 32'(iss_ready_o), 1);
      chk(mem_en_o == 1'b0, "R1 no memory access after reset", 32'(mem_en_o), 0);
      chk(ld_req_o == 1'b0, "R1 no bus request after reset", 32'(ld_req_o), 0);
   endtask

   task automatic t_load_timing();
      int a0 = acc_n;
      logic [3:0] tg;
      do_issue(1'b0, 32'h10, 4'd0, 12'd4, '0, 4'd0);
      tg = last_tag;
      @(negedge clk);
      chk(ld_req_o == 1'b0, "R7 no request one edge after address", 32'(ld_req_o), 0);
      @(negedge clk);
      chk(ld_req_o == 1'b0, "R7 no request during read latency", 32'(ld_req_o), 0);
      @(negedge clk);
      chk(ld_req_o == 1'b1, "R7 request three edges after issue", 32'(ld_req_o), 1);
      chk(ld_tag_o == tg, "R7 load tag", 32'(ld_tag_o), 32'(tg));
      chk(ld_data_o == minit(8'h14), "R7 load data", ld_data_o, minit(8'h14));
      chk(acc_addr[a0] == 8'h14, "R4 address base plus positive immediate", 32'(acc_addr[a0]), 32'h14);
      @(negedge clk);
      chk(ld_req_o == 1'b0, "R8 slot freed on grant", 32'(ld_req_o), 0);
   endtask

   task automatic t_neg_imm();
      int b0 = bc_n;
      do_issue(1'b0, 32'h40, 4'd0, 12'hFF8, '0, 4'd0);
      wait_bc(b0 + 1);
      chk(bc_data[b0] == minit(8'h38), "R4 negative immediate sign-extended", bc_data[b0], minit(8'h38));
   endtask

   task automatic t_base_wait();
      int a0 = acc_n, b0 = bc_n;
      do_issue(1'b0, 32'hFFFF, 4'd9, 12'd0, '0, 4'd0);
      repeat (6) @(negedge clk);
      chk(acc_n == a0, "R5 no access while base pending", 32'(acc_n - a0), 0);
      bcast(4'd9, 32'h20);
      wait_bc(b0 + 1);
      chk(bc_data[b0] == minit(8'h20), "R5 load uses broadcast base", bc_data[b0], minit(8'h20));
   endtask

   task automatic t_order();
      int a0 = acc_n;
      do_issue(1'b0, '0, 4'd9, 12'd2, '0, 4'd0);
      do_issue(1'b1, 32'h30, 4'd0, 12'd0, 32'h1234, 4'd0);
      repeat (6) @(negedge clk);
      chk(mem[8'h30] == minit(8'h30), "R6 younger store waits behind blocked head", mem[8'h30], minit(8'h30));
      bcast(4'd9, 32'h40);
      wait_acc(a0 + 2);
      @(negedge clk);
      chk(acc_we[a0] == 1'b0 && acc_addr[a0] == 8'h42, "R6 older load accesses first",
          {acc_we[a0], 23'd0, acc_addr[a0]}, 32'h42);
      chk(acc_we[a0+1] == 1'b1 && mem[8'h30] == 32'h1234, "R6 store follows", mem[8'h30], 32'h1234);
   endtask

   task automatic t_hold();
      logic [3:0]  tg;
      logic [31:0] dt;
      int b0 = bc_n;
      ld_gnt = 1'b0;
      do_issue(1'b0, 32'h08, 4'd0, 12'd0, '0, 4'd0);
      for (int i = 0; i < 10 && !ld_req_o; i++) @(negedge clk);
      tg = ld_tag_o; dt = ld_data_o;
      chk(dt == minit(8'h08), "R8 held load data", dt, minit(8'h08));
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(ld_req_o && ld_tag_o == tg && ld_data_o == dt, "R8 request held without grant",
             ld_data_o, dt);
      end
      ld_gnt = 1'b1;
      @(negedge clk);
      chk(ld_req_o == 1'b0 && bc_n == b0 + 1, "R8 released on grant", 32'(bc_n - b0), 1);
   endtask

   task automatic t_store_wait();
      int a0 = acc_n;
      do_issue(1'b1, 32'h50, 4'd0, 12'd0, '0, 4'd10);
      repeat (6) @(negedge clk);
      chk(mem[8'h50] == minit(8'h50), "R9 no write while data pending", mem[8'h50], minit(8'h50));
      bcast(4'd11, 32'h0BAD);
      repeat (4) @(negedge clk);
      chk(acc_n == a0, "R10 unrelated broadcast ignored", 32'(acc_n - a0), 0);
      bcast(4'd10, 32'hDEAD);
      wait_acc(a0 + 1);
      @(negedge clk);
      chk(mem[8'h50] == 32'hDEAD, "R9 store writes resolved data", mem[8'h50], 32'hDEAD);
   endtask

   task automatic t_snoop_both();
      int a0 = acc_n;
      do_issue(1'b1, '0, 4'd12, 12'd4, '0, 4'd13);
      bcast(4'd13, 32'h00C0FFEE);
      bcast(4'd12, 32'h60);
      wait_acc(a0 + 1);
      @(negedge clk);
      chk(mem[8'h64] == 32'h00C0FFEE, "R10 base and data both snooped", mem[8'h64], 32'h00C0FFEE);
   endtask

   task automatic t_bypass();
      int a0 = acc_n, b0 = bc_n;
      rb_valid = 1'b1; rb_tag = 4'd14; rb_data = 32'h77;
      do_issue(1'b1, 32'h68, 4'd0, 12'd0, '0, 4'd14);
      rb_valid = 1'b0;
      wait_acc(a0 + 1);
      @(negedge clk);
      chk(mem[8'h68] == 32'h77, "R11 data captured at issue", mem[8'h68], 32'h77);
      rb_valid = 1'b1; rb_tag = 4'd15; rb_data = 32'h18;
      do_issue(1'b0, '0, 4'd15, 12'd0, '0, 4'd0);
      rb_valid = 1'b0;
      wait_bc(b0 + 1);
      chk(bc_data[b0] == minit(8'h18), "R11 base captured at issue", bc_data[b0], minit(8'h18));
   endtask

   task automatic t_full();
      int a0 = acc_n, b0;
      bit hit = 1'b0;
      do_issue(1'b0, '0, 4'd9, 12'd0, '0, 4'd0);
      for (int k = 0; k < 3; k++) do_issue(1'b1, 32'h80 + 32'(4*k), 4'd0, 12'd0, 32'h100 + 32'(k), 4'd0);
      chk(iss_ready_o == 1'b0, "R2 not ready when full", 32'(iss_ready_o), 0);
      iss_valid = 1'b1; iss_store = 1'b1; iss_base_val = 32'h90; iss_base_tag = '0;
      iss_imm = '0; iss_data_val = 32'h99; iss_data_tag = '0;
      repeat (2) @(negedge clk);
      iss_valid = 1'b0;
      chk(iss_ready_o == 1'b0 && acc_n == a0, "R2 issue while full dropped", 32'(acc_n - a0), 0);
      bcast(4'd9, 32'h20);
      for (int i = 0; i < 40 && !hit; i++) begin
         if (mem_en_o && mem_we_o && iss_ready_o) hit = 1'b1;
         else @(negedge clk);
      end
      chk(hit, "R12 store retirement observed", 32'(hit), 1);
      do_issue(1'b1, 32'h94, 4'd0, 12'd0, 32'h55, 4'd0);
      chk(iss_ready_o == 1'b1, "R12 ready after simultaneous issue and release", 32'(iss_ready_o), 1);
      wait_acc(a0 + 5);
      repeat (3) @(negedge clk);
      chk(mem[8'h94] == 32'h55 && mem[8'h88] == 32'h102, "R12 new store lands", mem[8'h94], 32'h55);
      chk(mem[8'h90] == minit(8'h90) && acc_n == a0 + 5, "R2 dropped issue never reached memory",
          mem[8'h90], minit(8'h90));
      b0 = bc_n;
      do_issue(1'b0, '0, 4'd9, 12'd0, '0, 4'd0);
      for (int k = 0; k < 2; k++) do_issue(1'b0, 32'h04, 4'd0, 12'd0, '0, 4'd0);
      chk(iss_ready_o == 1'b1, "R12 ready with three occupied", 32'(iss_ready_o), 1);
      do_issue(1'b0, 32'h04, 4'd0, 12'd0, '0, 4'd0);
      chk(iss_ready_o == 1'b0, "R12 full after exactly four", 32'(iss_ready_o), 0);
      bcast(4'd9, 32'h0C);
      wait_bc(b0 + 4);
      chk(bc_n == b0 + 4 && bc_data[b0] == minit(8'h0C), "R12 all four loads broadcast",
          32'(bc_n - b0), 4);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = minit(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_timing();
      t_neg_imm();
      t_base_wait();
      t_order();
      t_hold();
      t_store_wait();
      t_snoop_both();
      t_bypass();
      t_full();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule